// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower, word-wide memory. It keeps a power-of-two number of one-word lines. Each line is selected by the low address bits and carries a valid flag, a tag made of the remaining high address bits, and one data word. A read that finds its word is answered in the same cycle. A read that does not find it holds the processor, fetches the word from memory, installs it, and then answers.

Every store goes to memory through a small posted-write queue. The processor only waits when that queue has no free entry. A store that finds its line also updates the line. A build-time parameter picks what happens to a store that misses. In allocate mode the word is fetched into the line first and the store then proceeds as a hit. In bypass mode only memory is updated. Before a read fetch is issued, the queue is emptied, so a fetch can never overtake a queued store to the same word.

The processor holds `cpu_req` and its fields stable until it sees `cpu_ready` high at a rising clock edge. The memory side holds `mem_req` and its fields until `mem_ack`. That acknowledge is a one-cycle pulse, which also carries `mem_rdata` for a read.

Top module: `wt_cache`

## Requirements
- R1: The line index is the low log2(LINES) bits of `cpu_addr` and the tag is the remaining high bits. A line holds exactly one tag, so a miss on an index replaces the previous tag there. With 8 lines, word addresses 22, 26, 22, 26, 16, 3, 16, 18 give miss, miss, hit, hit, miss, miss, hit, miss. After that, 26 misses and 22 hits.
- R2: Reset (synchronous, active high) clears every valid flag, so the first read of any address misses. After reset, with no request pending, `mem_req` and `cpu_ready` are 0.
- R3: A read hit raises `cpu_ready` in the cycle the request is presented, with `cpu_rdata` equal to the latest value written to that address.
- R4: A read miss keeps `cpu_ready` low and issues one memory read of the missing address. It writes the returned word and tag into the line. In the cycle after `mem_ack`, the still-held read hits and returns that word.
- R5: A store that hits updates the line, so a following read of the address hits with the new value. The store is also queued for memory.
- R6: A store that can proceed is accepted in the cycle it is presented whenever the queue (WB_DEPTH entries) has a free entry. With the queue full, `cpu_ready` stays low until an entry drains.
- R7: Queued stores reach memory in the order they were accepted, one request at a time. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ack`. A later store to the same address therefore wins.
- R8: No memory read is issued while the queue holds any store, so a read miss returns data that includes every earlier store.
- R9: With WRITE_ALLOC=1, a store miss first fetches the word into its line (stalling) and then completes as a hit. A following read of that address hits with the stored value.
- R10: With WRITE_ALLOC=0, a store miss is queued for memory without touching any line. The line at that index keeps its previous tag and data, and a following read of the stored address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when `cpu_ready` is high for a load |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion pulse from memory |

## Verification
The bench builds two copies side by side, one per store-miss policy. Both use a 5-bit address, 16-bit data, 8 lines and a 4-entry queue, in front of a memory model with a latency of 6 cycles. With only 32 addresses, four conflicting tags per line and a queue that five back-to-back stores can overflow, a few hundred pseudo-random accesses cover every line, every replacement and the full-queue stall. The final state of the memory model can also be compared word by word with the bench's own arithmetic model.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

  // Controller phases: serve lookups, or wait for a line fill
  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } ctl_state_t;

endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  // Valid flags need a reset; tag and data arrays stay plain RAM
  always_ff @(posedge clk) begin
    if (rst)        valid_q         <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

endmodule

// File: rtl/wt_post_fifo.sv
module wt_post_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 48,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W:0]   wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr[PTR_W-1:0]] <= din;
  end

  assign dout  = slots[rd_ptr[PTR_W-1:0]];
  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                 (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);

endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LINES       = 64,
  parameter int WB_DEPTH    = 4,
  parameter int WRITE_ALLOC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ENT_W = ADDR_W + DATA_W;

  ctl_state_t        state;
  logic [ADDR_W-1:0] miss_addr;

  logic              lk_valid;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              hit, lookup;
  logic              wmiss_post, wmiss_fill;
  logic              rd_ok, wr_ok, go_fill, fill_done;

  logic              ls_we;
  logic [IDX_W-1:0]  ls_idx;
  logic [TAG_W-1:0]  ls_tag;
  logic [DATA_W-1:0] ls_data;

  logic              wb_empty, wb_full, wb_pop;
  logic [ENT_W-1:0]  wb_head;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;

  wt_line_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) lines_i (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (cpu_addr[IDX_W-1:0]),
    .rd_valid(lk_valid),
    .rd_tag  (lk_tag),
    .rd_data (lk_data),
    .wr_en   (ls_we),
    .wr_idx  (ls_idx),
    .wr_tag  (ls_tag),
    .wr_data (ls_data)
  );

  wt_post_fifo #(
    .DEPTH(WB_DEPTH),
    .WIDTH(ENT_W)
  ) wbuf_i (
    .clk  (clk),
    .rst  (rst),
    .push (wr_ok),
    .din  ({cpu_addr, cpu_wdata}),
    .pop  (wb_pop),
    .dout (wb_head),
    .empty(wb_empty),
    .full (wb_full)
  );

  assign head_addr = wb_head[ENT_W-1:DATA_W];
  assign head_data = wb_head[DATA_W-1:0];

  // Store-miss policy chosen at build time
  generate
    if (WRITE_ALLOC != 0) begin : g_alloc
      assign wmiss_post = 1'b0;
      assign wmiss_fill = 1'b1;
    end else begin : g_bypass
      assign wmiss_post = 1'b1;
      assign wmiss_fill = 1'b0;
    end
  endgenerate

  assign hit       = lk_valid && (lk_tag == cpu_addr[ADDR_W-1:IDX_W]);
  assign lookup    = (state == ST_LOOKUP) && cpu_req;
  assign rd_ok     = lookup && !cpu_we && hit;
  assign wr_ok     = lookup && cpu_we && !wb_full && (hit || wmiss_post);
  assign go_fill   = lookup && !hit && (!cpu_we || wmiss_fill);
  // A fill completes only on the read acknowledge, after the queue is empty
  assign fill_done = (state == ST_FILL) && mem_ack && wb_empty;

  assign ls_we   = fill_done || (wr_ok && hit);
  assign ls_idx  = fill_done ? miss_addr[IDX_W-1:0]      : cpu_addr[IDX_W-1:0];
  assign ls_tag  = fill_done ? miss_addr[ADDR_W-1:IDX_W] : cpu_addr[ADDR_W-1:IDX_W];
  assign ls_data = fill_done ? mem_rdata                 : cpu_wdata;

  assign cpu_ready = rd_ok || wr_ok;
  assign cpu_rdata = lk_data;

  // Queued stores own the memory port; a fill reads only once they are gone
  assign wb_pop    = mem_ack && !wb_empty;
  assign mem_req   = !wb_empty || (state == ST_FILL);
  assign mem_we    = !wb_empty;
  assign mem_addr  = wb_empty ? miss_addr : head_addr;
  assign mem_wdata = head_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOOKUP;
      miss_addr <= '0;
    end else begin
      case (state)
        ST_LOOKUP: if (go_fill) begin
          state     <= ST_FILL;
          miss_addr <= cpu_addr;
        end
        ST_FILL: if (fill_done) state <= ST_LOOKUP;
        default: state <= ST_LOOKUP;
      endcase
    end
  end

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              wb_empty,
  input logic              wb_full
);

  // R7: a memory request and its fields hold until acknowledged
  p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) &&
                            $stable(mem_addr) && $stable(mem_wdata));

  // R6: no store is accepted while the queue is full
  p_no_accept_full_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_we && cpu_ready |-> !wb_full);

  // R6: the queue cannot be full and empty at once
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(wb_empty && wb_full));

  // R5: an accepted store leaves the queue non-empty
  p_store_queued_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_we && cpu_ready |=> !wb_empty);

  // R4: the read answered by memory completes on the next cycle
  p_fill_completes_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_we && mem_req && !mem_we && mem_ack |=> cpu_ready);

  // R8: a memory read is only issued with the queue empty
  p_read_after_drain_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> wb_empty && !cpu_ready);

endmodule

bind wt_cache wt_cache_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cpu_req  (cpu_req),
  .cpu_we   (cpu_we),
  .cpu_ready(cpu_ready),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack),
  .wb_empty (wb_empty),
  .wb_full  (wb_full)
);

// File: tb/wt_cache_tb_top.sv
module wt_mem_model #(
  parameter int AW  = 5,
  parameter int DW  = 16,
  parameter int LAT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ack
);
  logic [DW-1:0] mem [2**AW];
  int cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
      cnt   <= 0;
      for (int i = 0; i < 2**AW; i++) mem[i] <= DW'(i * 97 + 13);
    end else if (ack) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (req) begin
      if (cnt == LAT - 1) begin
        ack <= 1'b1;
        cnt <= 0;
        rdata <= mem[addr];
        if (we) mem[addr] <= wdata;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module wt_cache_tb_top;
  localparam int AW = 5, DW = 16, LN = 8, WBD = 4, LAT = 6;
  localparam int NA = 2**AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  int            sel = 0;   // 0: allocate copy, 1: bypass copy

  logic [DW-1:0] rdata0, rdata1, m0_wd, m1_wd, m0_rd, m1_rd;
  logic          ready0, ready1, m0_req, m1_req, m0_we, m1_we, m0_ack, m1_ack;
  logic [AW-1:0] m0_a, m1_a;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN), .WB_DEPTH(WBD), .WRITE_ALLOC(1)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req && sel == 0), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata0), .cpu_ready(ready0),
    .mem_req(m0_req), .mem_we(m0_we), .mem_addr(m0_a), .mem_wdata(m0_wd),
    .mem_rdata(m0_rd), .mem_ack(m0_ack));

  wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN), .WB_DEPTH(WBD), .WRITE_ALLOC(0)) dut_wa_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req && sel == 1), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata1), .cpu_ready(ready1),
    .mem_req(m1_req), .mem_we(m1_we), .mem_addr(m1_a), .mem_wdata(m1_wd),
    .mem_rdata(m1_rd), .mem_ack(m1_ack));

  wt_mem_model #(.AW(AW), .DW(DW), .LAT(LAT)) mm0_i (
    .clk(clk), .rst(rst), .req(m0_req), .we(m0_we), .addr(m0_a), .wdata(m0_wd),
    .rdata(m0_rd), .ack(m0_ack));
  wt_mem_model #(.AW(AW), .DW(DW), .LAT(LAT)) mm1_i (
    .clk(clk), .rst(rst), .req(m1_req), .we(m1_we), .addr(m1_a), .wdata(m1_wd),
    .rdata(m1_rd), .ack(m1_ack));

  int errors = 0, checks = 0;
  logic [DW-1:0] ref_mem [NA];
  bit            bv [LN];
  int            bt [LN];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (copy %0d)", req, what, act, exp, sel);
    end
  endtask

  task automatic access(input bit we, input int a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int st);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd; st = 0;
    #1;
    while (!((sel == 0) ? ready0 : ready1) && st < 500) begin
      @(negedge clk); #1; st++;
    end
    rd = (sel == 0) ? rdata0 : rdata1;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  function automatic bit model_hit(input int a);
    return bv[a % LN] && bt[a % LN] == a / LN;
  endfunction

  // Read with hit/miss and data checked against the bench model
  task automatic rd(input int a, input string req, output bit was_hit);
    logic [DW-1:0] d; int st; bit h;
    h = model_hit(a);
    access(1'b0, a, '0, d, st);
    chk((st == 0) == h, req, $sformatf("read %0d stall cycles (hit=%0d)", a, h), st, h ? 0 : LAT);
    chk(d == ref_mem[a], req, $sformatf("read %0d data", a), int'(d), int'(ref_mem[a]));
    bv[a % LN] = 1'b1; bt[a % LN] = a / LN;
    was_hit = h;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, output int st);
    logic [DW-1:0] dummy;
    if (!model_hit(a) && sel == 0) begin
      bv[a % LN] = 1'b1; bt[a % LN] = a / LN;
    end
    access(1'b1, a, d, dummy, st);
    ref_mem[a] = d;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NA; i++) ref_mem[i] = DW'(i * 97 + 13);
    for (int i = 0; i < LN; i++) begin bv[i] = 1'b0; bt[i] = 0; end
  endtask

  task automatic run_copy();
    bit h; int st; int seq [8]; bit exph [8]; int unsigned lcg;
    logic [DW-1:0] mv;
    do_reset();
    repeat (2) @(negedge clk);
    // R2: idle after reset
    chk(((sel == 0) ? m0_req : m1_req) == 1'b0, "R2", "mem_req after reset", 1, 0);
    chk(((sel == 0) ? ready0 : ready1) == 1'b0, "R2", "cpu_ready idle", 1, 0);

    // R1/R2: reference sequence on 8 lines
    seq = '{22, 26, 22, 26, 16, 3, 16, 18};
    exph = '{0, 0, 1, 1, 0, 0, 1, 0};
    for (int i = 0; i < 8; i++) begin
      rd(seq[i], "R1", h);
      chk(h == exph[i], "R1", $sformatf("hit pattern step %0d", i), h, exph[i]);
    end
    rd(26, "R1", h); chk(h == 1'b0, "R1", "26 replaced by 18", h, 0);
    rd(22, "R3", h); chk(h == 1'b1, "R3", "22 still present", h, 1);
    rd(18, "R4", h); chk(h == 1'b0, "R4", "18 refetched after 26", h, 0);

    // R5: store hit updates line and memory
    wr(22, 16'hBEEF, st);
    chk(st == 0, "R5", "store hit accepted at once", st, 0);
    rd(22, "R5", h); chk(h == 1'b1, "R5", "read after store hit", h, 1);
    repeat (30) @(negedge clk);
    mv = (sel == 0) ? mm0_i.mem[22] : mm1_i.mem[22];
    chk(mv == 16'hBEEF, "R5", "memory after store hit", int'(mv), 'hBEEF);

    // R6: four stores posted, fifth waits for a free entry
    wr(16, 16'h1111, st); chk(st == 0, "R6", "post 1", st, 0);
    wr(3,  16'h2222, st); chk(st == 0, "R6", "post 2", st, 0);
    wr(18, 16'h3333, st); chk(st == 0, "R6", "post 3", st, 0);
    wr(22, 16'h4444, st); chk(st == 0, "R6", "post 4", st, 0);
    wr(16, 16'h5555, st); chk(st > 0, "R6", "fifth store stalls", st, 1);
    repeat (60) @(negedge clk);
    mv = (sel == 0) ? mm0_i.mem[16] : mm1_i.mem[16];
    chk(mv == 16'h5555, "R7", "later store to 16 wins", int'(mv), 'h5555);

    // R8/R9/R10: store miss to 30 (index 6 holds 22)
    if (sel == 0) begin
      wr(30, 16'h0A0A, st); chk(st > 0, "R9", "store miss fetches", st, 1);
      rd(30, "R9", h); chk(h == 1'b1, "R9", "30 allocated", h, 1);
      rd(22, "R9", h); chk(h == 1'b0, "R9", "22 evicted", h, 0);
    end else begin
      wr(30, 16'h0A0A, st); chk(st == 0, "R10", "store miss posted", st, 0);
      wr(30, 16'h0B0B, st); chk(st == 0, "R10", "second store miss posted", st, 0);
      rd(22, "R10", h); chk(h == 1'b1, "R10", "line 6 untouched", h, 1);
      rd(30, "R8", h); chk(h == 1'b0, "R8", "30 misses after bypass", h, 0);
    end

    // Near-exhaustive pseudo-random mix (R1, R3, R4, R5, R8)
    lcg = 32'd12345 + 32'(sel);
    for (int i = 0; i < 300; i++) begin
      int a;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      a = int'((lcg >> 16) % NA);
      if (((lcg >> 8) & 3) == 0) wr(a, DW'(lcg >> 3), st);
      else rd(a, "R8", h);
    end

    // R7: memory image after draining
    repeat (60) @(negedge clk);
    for (int i = 0; i < NA; i++) begin
      mv = (sel == 0) ? mm0_i.mem[i] : mm1_i.mem[i];
      chk(mv == ref_mem[i], "R7", $sformatf("memory word %0d", i), int'(mv), int'(ref_mem[i]));
    end
  endtask

  initial begin
    sel = 0; run_copy();
    sel = 1; run_copy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule